// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that finishes every instruction in one clock cycle. It runs a subset of nine instructions: four two-operand logic and arithmetic operations, a signed set-less-than, a word load, a word store, an equality branch and an absolute jump. It holds a program counter, a 32-entry register file, a word-addressed instruction array and a separate word-addressed data array.

At the start of each cycle the program counter selects an instruction. The core decodes it and reads its register operands. The effective address of a load or store is captured on the falling clock edge, so the data array is read or written in the second half of the cycle that computed the address. On the rising edge the core commits the next program counter, any register write and any store.

A bench or a host loads both arrays through a simple write port while the core is held in reset. It can then look at any register, any data word and the program counter through read-only outputs.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0.
- R2: Opcode 0 is register-to-register. Function codes 0x20, 0x22, 0x24 and 0x25 write rs+rt, rs-rt, rs AND rt and rs OR rt to rd. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0].
- R3: Function code 0x2A writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R4: Opcode 0x23 loads the data word at rs + sign-extended imm[15:0] into rt. Opcode 0x2B stores rt to that word. The address is taken on the falling edge, and a load in the cycle after a store returns the stored word.
- R5: Opcode 0x04 compares rs and rt. If they are equal the next PC is PC+4 + (sign-extended imm << 2), otherwise PC+4. Backward offsets work.
- R6: Opcode 0x02 sets the PC to {PC+4 [31:28], instr[25:0], 2'b00}.
- R7: Register 0 always reads as 0, and writes aimed at it are discarded.
- R8: An opcode outside the subset changes no register and no data word, and advances the PC by 4.
- R9: Every instruction other than a taken branch or a jump advances the PC by exactly 4 in a single cycle.
- R10: With `load_we` high at a rising edge, `load_data` is written to word `load_addr` of the data array if `load_dmem` is 1, and of the instruction array if it is 0. `peek_reg_val`, `peek_mem_val` and `pc_out` show the current contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commit on rising edge, address capture on falling edge |
| rst | input | 1 | Synchronous reset, active high |
| load_we | input | 1 | Preload write strobe |
| load_dmem | input | 1 | Preload target: 1 data array, 0 instruction array |
| load_addr | input | AW | Preload word index |
| load_data | input | 32 | Preload word |
| peek_reg_sel | input | 5 | Register to observe |
| peek_reg_val | output | 32 | Value of selected register |
| peek_mem_addr | input | AW | Data word to observe |
| peek_mem_val | output | 32 | Value of selected data word |
| pc_out | output | 32 | Current program counter |

## Verification
The test program is built to expose specific faults. A negative load offset shows up as the wrong word if the offset is zero-extended. A store followed at once by a load of the same word would return stale data if the address were captured at the wrong edge. A set-less-than on a negative operand would flip its result if the compare were unsigned. Skipped instructions after a taken branch and after a jump leave their target registers at 0 only when the target arithmetic is right. An undefined opcode whose low fields spell an add would corrupt a register if the decode checked only the function code. A write to register 0 and a backward self-branch complete the set.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_we,
  input  logic          load_dmem,
  input  logic [AW-1:0] load_addr,
  input  logic [31:0]   load_data,
  input  logic [4:0]    peek_reg_sel,
  output logic [31:0]   peek_reg_val,
  input  logic [AW-1:0] peek_mem_addr,
  output logic [31:0]   peek_mem_val,
  output logic [31:0]   pc_out
);
  logic [31:0] imem [WORDS];
  logic [31:0] dmem [WORDS];
  logic [31:0] rf [32];
  logic [31:0] pc;
  logic [AW-1:0] ls_idx_q;

  logic [31:0] instr;
  assign instr = imem[pc[AW+1:2]];

  logic [5:0] op, funct;
  logic [4:0] rs, rt, rd;
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];

  logic [31:0] rs_val, rt_val, simm;
  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign simm   = {{16{instr[15]}}, instr[15:0]};

  logic is_r, is_lw, is_sw, is_beq, is_j;
  assign is_r   = (op == 6'h00);
  assign is_lw  = (op == 6'h23);
  assign is_sw  = (op == 6'h2B);
  assign is_beq = (op == 6'h04);
  assign is_j   = (op == 6'h02);

  logic [31:0] r_res;
  logic        r_ok;
  always_comb begin
    r_ok  = 1'b1;
    r_res = 32'd0;
    case (funct)
      6'h20: r_res = rs_val + rt_val;
      6'h22: r_res = rs_val - rt_val;
      6'h24: r_res = rs_val & rt_val;
      6'h25: r_res = rs_val | rt_val;
      6'h2A: r_res = {31'd0, $signed(rs_val) < $signed(rt_val)};
      default: r_ok = 1'b0;
    endcase
  end

  logic [31:0] ea;
  assign ea = rs_val + simm;

  always_ff @(negedge clk)
    ls_idx_q <= ea[AW+1:2];

  logic [31:0] ld_data;
  assign ld_data = dmem[ls_idx_q];

  logic [31:0] pc4, next_pc;
  assign pc4 = pc + 32'd4;
  always_comb begin
    next_pc = pc4;
    if (is_beq && rs_val == rt_val) next_pc = pc4 + {simm[29:0], 2'b00};
    else if (is_j)                  next_pc = {pc4[31:28], instr[25:0], 2'b00};
  end

  logic        wr_en;
  logic [4:0]  wr_sel;
  logic [31:0] wr_val;
  assign wr_en  = (is_r && r_ok) || is_lw;
  assign wr_sel = is_lw ? rt : rd;
  assign wr_val = is_lw ? ld_data : r_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      pc <= next_pc;
      if (wr_en && wr_sel != 5'd0) rf[wr_sel] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (load_we && !load_dmem) imem[load_addr] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (load_we && load_dmem) dmem[load_addr] <= load_data;
    else if (!rst && is_sw)   dmem[ls_idx_q] <= rt_val;
  end

  assign peek_reg_val = (peek_reg_sel == 5'd0) ? 32'd0 : rf[peek_reg_sel];
  assign peek_mem_val = dmem[peek_mem_addr];
  assign pc_out       = pc;
endmodule

module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc_out,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [4:0]  peek_reg_sel,
  input logic [31:0] peek_reg_val
);
  logic [5:0] op;
  assign op = instr[31:26];

  a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc_out == 32'd0);

  a_r9_pc_step: assert property (@(posedge clk) disable iff (rst)
    (op != 6'h04 && op != 6'h02) |=> pc_out == $past(pc_out) + 32'd4);

  a_r5_beq_not_taken: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val != rt_val) |=> pc_out == $past(pc_out) + 32'd4);

  a_r5_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val == rt_val) |=>
      pc_out == $past(pc_out) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    op == 6'h02 |=>
      pc_out == ((($past(pc_out) + 32'd4) & 32'hF000_0000) | {4'd0, $past(instr[25:0]), 2'b00}));

  a_r7_r0_reads_zero: assert property (@(posedge clk)
    peek_reg_sel == 5'd0 |-> peek_reg_val == 32'd0);
endmodule

bind sc_core sc_core_chk chk (
  .clk(clk), .rst(rst), .pc_out(pc_out), .instr(instr),
  .rs_val(rs_val), .rt_val(rt_val),
  .peek_reg_sel(peek_reg_sel), .peek_reg_val(peek_reg_val)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 64;
  localparam int AW = $clog2(WORDS);

  function automatic logic [31:0] enc_r(input int f, input int d, input int s, input int t);
    return {6'd0, s[4:0], t[4:0], d[4:0], 5'd0, f[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(input int op, input int t, input int s, input int imm);
    return {op[5:0], s[4:0], t[4:0], imm[15:0]};
  endfunction

  localparam int NPROG = 25;
  localparam logic [31:0] PROG [NPROG] = '{
    enc_i(8'h23, 1, 0, 0),            // 0  lw r1,0(r0)
    enc_i(8'h23, 2, 0, 4),            // 1  lw r2,4(r0)
    enc_i(8'h23, 3, 0, 8),            // 2  lw r3,8(r0)
    enc_i(8'h23, 4, 0, 12),           // 3  lw r4,12(r0)
    enc_r(8'h20, 5, 1, 2),            // 4  add
    enc_r(8'h22, 6, 1, 2),            // 5  sub
    enc_r(8'h24, 7, 4, 6),            // 6  and
    enc_r(8'h25, 8, 1, 2),            // 7  or
    enc_r(8'h2A, 9, 3, 1),            // 8  slt -3<5
    enc_r(8'h2A, 10, 1, 3),           // 9  slt 5<-3
    enc_r(8'h20, 0, 1, 2),            // 10 add into r0
    enc_i(8'h2B, 5, 0, 16),           // 11 sw r5,16(r0)
    enc_i(8'h23, 11, 5, -4),          // 12 lw r11,-4(r5)
    enc_i(8'h2B, 8, 0, 20),           // 13 sw r8,20(r0)
    enc_i(8'h23, 12, 0, 20),          // 14 lw r12,20(r0)
    enc_i(8'h04, 2, 1, 5),            // 15 beq not taken
    enc_i(8'h04, 7, 7, 2),            // 16 beq taken -> 19
    enc_r(8'h20, 13, 1, 1),           // 17 skipped
    enc_r(8'h20, 13, 2, 2),           // 18 skipped
    {6'h02, 26'd22},                  // 19 j 22
    enc_r(8'h20, 14, 1, 1),           // 20 skipped
    enc_r(8'h20, 14, 1, 1),           // 21 skipped
    {6'h3F, 5'd1, 5'd2, 5'd1, 5'd0, 6'h20}, // 22 undefined opcode
    enc_r(8'h20, 15, 9, 9),           // 23 add r15
    enc_i(8'h04, 0, 0, -1)            // 24 beq self
  };

  localparam logic [31:0] EXP_REG [16] = '{
    32'h0, 32'h5, 32'h7, 32'hFFFF_FFFD, 32'h0F0F_00FF, 32'hC, 32'hFFFF_FFFE, 32'h0F0F_00FE,
    32'h7, 32'h1, 32'h0, 32'hFFFF_FFFD, 32'h7, 32'h0, 32'h0, 32'h2
  };
  localparam string REG_TAG [16] = '{
    "R7", "R4", "R4", "R4", "R4", "R2", "R2", "R2",
    "R2", "R3", "R3", "R4", "R4", "R5", "R6", "R8"
  };

  logic clk = 0, rst = 1, load_we = 0, load_dmem = 0;
  logic [AW-1:0] load_addr = '0, peek_mem_addr = '0;
  logic [31:0] load_data = '0;
  logic [4:0] peek_reg_sel = '0;
  logic [31:0] peek_reg_val, peek_mem_val, pc_out;
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core #(.WORDS(WORDS)) u0 (
    .clk(clk), .rst(rst), .load_we(load_we), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data),
    .peek_reg_sel(peek_reg_sel), .peek_reg_val(peek_reg_val),
    .peek_mem_addr(peek_mem_addr), .peek_mem_val(peek_mem_val), .pc_out(pc_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic dsel, input int a, input logic [31:0] d);
    @(posedge clk); #1;
    load_we = 1; load_dmem = dsel; load_addr = a[AW-1:0]; load_data = d;
    @(posedge clk); #1;
    load_we = 0;
  endtask

  task automatic peek_reg(input int r, output logic [31:0] v);
    peek_reg_sel = r[4:0]; #1; v = peek_reg_val;
  endtask

  task automatic peek_mem(input int a, output logic [31:0] v);
    peek_mem_addr = a[AW-1:0]; #1; v = peek_mem_val;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 32; i++) load(1'b0, i, 32'hFC00_0000); // undefined fill
    for (int i = 0; i < NPROG; i++) load(1'b0, i, PROG[i]);
    load(1'b1, 0, 32'h5);
    load(1'b1, 1, 32'h7);
    load(1'b1, 2, 32'hFFFF_FFFD);
    load(1'b1, 3, 32'h0F0F_00FF);
    load(1'b1, 4, 32'h0);
    load(1'b1, 5, 32'h0);
    @(negedge clk);
    check("R1 reset pc", pc_out, 32'h0);
    peek_reg(5, v); check("R1 reset r5", v, 32'h0);
    peek_mem(3, v); check("R10 preload dmem[3]", v, 32'h0F0F_00FF);

    @(posedge clk); #1; rst = 0;
    @(posedge clk); #1;
    check("R9 first step pc", pc_out, 32'h4);
    peek_reg(1, v); check("R4 lw r1", v, 32'h5);

    repeat (40) @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < 16; r++) begin
      peek_reg(r, v);
      check($sformatf("%s reg %0d", REG_TAG[r], r), v, EXP_REG[r]);
    end
    peek_mem(4, v); check("R4 sw dmem[4]", v, 32'hC);
    peek_mem(5, v); check("R4 sw dmem[5]", v, 32'h7);
    check("R5 backward self branch pc", pc_out, 32'h60);
    @(posedge clk); #1;
    check("R5 self branch holds pc", pc_out, 32'h60);

    rst = 1;
    @(posedge clk); #1;
    rst = 0;
    check("R1 re-reset pc", pc_out, 32'h0);
    peek_reg(5, v); check("R1 re-reset r5", v, 32'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule